// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control unit of a small byte-wide processor. A sixteen-step timing counter runs continuously. On each step a microcode lookup produces the 16-bit control word that drives the datapath: register loads and output enables, memory and address-register strobes, program-counter actions, the ALU function, and the output-latch and stop bits. The lookup is indexed by the current step and by the opcode held in the instruction register.

Every instruction starts with the same three-step prologue. Step 0 fetches the opcode through the program-counter address and advances the counter. Step 1 loads the address register from the program counter. Step 2 is an idle branch point. From step 3 onward the word depends on the opcode. When an instruction has finished its steps, every later step outputs an all-zero word until the counter wraps back to step 0. A halt input freezes the timing counter and forces the word to zero.

The step counter is 4 bits wide. Its top bit chooses which of two eight-output decode halves drives the one-hot step bus.

Top module: `useq_ctrl`

## Requirements
- R1: Outside reset and halt, the step counter advances by one on each rising clock edge from step 0 to step 15, and returns to step 0 after step 15.
- R2: `tstate_o` is one-hot with bit k set in step k. Bits 0–7 can be set only while the counter's top bit is 0, and bits 8–15 only while it is 1.
- R3: While `rst_n_i` is low, the counter is forced to step 0, so `tstate_o` = 0x0001.
- R4: When not halted, the control word is 0x418F in step 0 (fetch through PC with MDR load and PC increment), 0x0028 in step 1 (full address-register load) and 0x0000 in step 2, for any opcode.
- R5: Opcode 0x11 (load A immediate) gives 0x418F in step 3 and 0x0001 (A load) in step 4.
- R6: Opcode 0x12 (load B immediate) gives 0x418F in step 3 and 0x0002 (B load) in step 4.
- R7: Opcode 0x21 (store A) gives 0x418A, 0x418B, 0x0025, 0x0036 and 0x001C in steps 3 to 7.
- R8: Opcode 0x22 (store B) gives 0x4189, 0x418B, 0x0024, 0x0036 and 0x001D in steps 3 to 7.
- R9: Any step after an opcode's last defined step outputs 0x0000. In particular, steps 8–15 always output 0x0000.
- R10: Any opcode other than 0x11, 0x12, 0x21 and 0x22 outputs 0x0000 in steps 3–15.
- R11: While `halt_i` is high, the control word is 0x0000 and the step does not change at the next edge.

Control-word fields, from the low bits up:
- [2:0] register action: 1/2/3 load A/B/C, 4/5/6 drive A/B/C, 7 load MDR.
- [5:3] memory action: 1 ROM read, 2 RAM read, 3 RAM write, 4 address low load, 5 full address load, 6 address high load.
- [8:6] PC action: 1 clear, 2 preset, 5 stop, 6 increment, 7 decrement.
- [11:9] ALU function.
- [12] output latch load.
- [13] output latch read.
- [14] address source (1 = PC).
- [15] stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| halt_i | input | 1 | Halt feedback; freezes the step and forces a zero word |
| ir_i | input | 8 | Current instruction-register opcode |
| tstate_o | output | 16 | One-hot timing step |
| cword_o | output | 16 | Control word for the current step |

## Verification
The assertions check several properties on every cycle: the step bus stays one-hot, it rotates by one position when not halted, it freezes and the word goes to zero under halt, the step-0 fetch word is correct, steps 8–15 are quiet, and unknown opcodes stay quiet after the prologue. Only the bench scenarios can show the exact per-step words of each defined opcode, the mid-instruction halt followed by a correct resume, and a reset asserted in the middle of an instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int STATE_W = 4;
  localparam int OP_W    = 8;
  localparam int FLD_W   = 3;

  typedef logic [FLD_W-1:0] fld_t;

  // register action field
  localparam fld_t RG_NONE  = 3'd0;
  localparam fld_t RG_A_LD  = 3'd1;
  localparam fld_t RG_B_LD  = 3'd2;
  localparam fld_t RG_C_LD  = 3'd3;
  localparam fld_t RG_A_OE  = 3'd4;
  localparam fld_t RG_B_OE  = 3'd5;
  localparam fld_t RG_C_OE  = 3'd6;
  localparam fld_t RG_MD_LD = 3'd7;

  // memory action field
  localparam fld_t MM_NONE  = 3'd0;
  localparam fld_t MM_ROM   = 3'd1;
  localparam fld_t MM_RAMRD = 3'd2;
  localparam fld_t MM_RAMWR = 3'd3;
  localparam fld_t MM_ADLO  = 3'd4;
  localparam fld_t MM_ADALL = 3'd5;
  localparam fld_t MM_ADHI  = 3'd6;

  // program counter action field
  localparam fld_t PC_NONE  = 3'd0;
  localparam fld_t PC_CLR   = 3'd1;
  localparam fld_t PC_SET   = 3'd2;
  localparam fld_t PC_STOP  = 3'd5;
  localparam fld_t PC_INC   = 3'd6;
  localparam fld_t PC_DEC   = 3'd7;

  localparam fld_t ALU_OFF  = 3'd0;

  typedef struct packed {
    logic stop;
    logic src_pc;
    logic olat_rd;
    logic olat_ld;
    fld_t alu;
    fld_t pc;
    fld_t mem;
    fld_t rg;
  } cword_t;

  localparam logic [OP_W-1:0] OPC_LDA_IMM = 8'h11;
  localparam logic [OP_W-1:0] OPC_LDB_IMM = 8'h12;
  localparam logic [OP_W-1:0] OPC_STO_A   = 8'h21;
  localparam logic [OP_W-1:0] OPC_STO_B   = 8'h22;

  function automatic cword_t mk_word(logic sp, fld_t pc, fld_t mem, fld_t rg);
    cword_t w;
    w         = '0;
    w.src_pc  = sp;
    w.alu     = ALU_OFF;
    w.pc      = pc;
    w.mem     = mem;
    w.rg      = rg;
    return w;
  endfunction

endpackage

// File: rtl/useq_timer.sv
module useq_timer #(
  parameter int STATE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               adv_i,
  output logic [STATE_W-1:0] count_o
);

  logic [STATE_W-1:0] count_q;
  logic [STATE_W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (adv_i) begin
      count_d = count_q + STATE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/useq_tdecode.sv
module useq_tdecode #(
  parameter int STATE_W = 4
) (
  input  logic [STATE_W-1:0]      count_i,
  output logic [(1<<STATE_W)-1:0] onehot_o
);

  localparam int NSTATE = 1 << STATE_W;
  localparam int NHALF  = NSTATE / 2;
  localparam int LOW_W  = STATE_W - 1;

  logic [LOW_W-1:0] low_sel;
  assign low_sel = count_i[LOW_W-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic half_en;
    assign half_en = (count_i[STATE_W-1] == h[0]);
    for (genvar i = 0; i < NHALF; i++) begin : g_out
      assign onehot_o[h*NHALF+i] = half_en && (low_sel == LOW_W'(i));
    end
  end

endmodule

// File: rtl/useq_urom.sv
module useq_urom
  import useq_pkg::*;
#(
  parameter int STATE_W = 4,
  parameter int OP_W    = 8
) (
  input  logic [STATE_W-1:0] step_i,
  input  logic [OP_W-1:0]    opc_i,
  output cword_t             word_o
);

  // prologue and execute words
  localparam cword_t W_FETCH = mk_word(1'b1, PC_INC,  MM_ROM,   RG_MD_LD);
  localparam cword_t W_ADDR  = mk_word(1'b0, PC_NONE, MM_ADALL, RG_NONE);
  localparam cword_t W_NOP   = '0;

  cword_t exec_word;

  always_comb begin
    exec_word = W_NOP;
    unique case (opc_i)
      OPC_LDA_IMM, OPC_LDB_IMM: begin
        if (step_i == STATE_W'(3)) begin
          exec_word = mk_word(1'b1, PC_INC, MM_ROM, RG_MD_LD);
        end else if (step_i == STATE_W'(4)) begin
          exec_word = mk_word(1'b0, PC_NONE, MM_NONE,
                              (opc_i == OPC_LDA_IMM) ? RG_A_LD : RG_B_LD);
        end
      end
      OPC_STO_A, OPC_STO_B: begin
        if (step_i == STATE_W'(3)) begin
          exec_word = mk_word(1'b1, PC_INC, MM_ROM,
                              (opc_i == OPC_STO_A) ? RG_B_LD : RG_A_LD);
        end else if (step_i == STATE_W'(4)) begin
          exec_word = mk_word(1'b1, PC_INC, MM_ROM, RG_C_LD);
        end else if (step_i == STATE_W'(5)) begin
          exec_word = mk_word(1'b0, PC_NONE, MM_ADLO,
                              (opc_i == OPC_STO_A) ? RG_B_OE : RG_A_OE);
        end else if (step_i == STATE_W'(6)) begin
          exec_word = mk_word(1'b0, PC_NONE, MM_ADHI, RG_C_OE);
        end else if (step_i == STATE_W'(7)) begin
          exec_word = mk_word(1'b0, PC_NONE, MM_RAMWR,
                              (opc_i == OPC_STO_A) ? RG_A_OE : RG_B_OE);
        end
      end
      default: exec_word = W_NOP;
    endcase
  end

  always_comb begin
    unique case (step_i)
      STATE_W'(0): word_o = W_FETCH;
      STATE_W'(1): word_o = W_ADDR;
      STATE_W'(2): word_o = W_NOP;
      default:     word_o = exec_word;
    endcase
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int SW = useq_pkg::STATE_W,
  parameter int OW = useq_pkg::OP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 halt_i,
  input  logic [OW-1:0]        ir_i,
  output logic [(1<<SW)-1:0]   tstate_o,
  output logic [$bits(cword_t)-1:0] cword_o
);

  logic [SW-1:0] count;
  logic          advance;
  cword_t        rom_word;

  assign advance = ~halt_i;

  useq_timer #(.STATE_W(SW)) u_timer (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .adv_i   (advance),
    .count_o (count)
  );

  useq_tdecode #(.STATE_W(SW)) u_dec (
    .count_i  (count),
    .onehot_o (tstate_o)
  );

  useq_urom #(.STATE_W(SW), .OP_W(OW)) u_rom (
    .step_i (count),
    .opc_i  (ir_i),
    .word_o (rom_word)
  );

  assign cword_o = halt_i ? '0 : rom_word;

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int N  = 16,
  parameter int OW = 8
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic          halt_i,
  input logic [OW-1:0] ir_i,
  input logic [N-1:0]  tstate_o,
  input logic [15:0]   cword_o
);

  logic known_op;
  assign known_op = (ir_i == 8'h11) || (ir_i == 8'h12) ||
                    (ir_i == 8'h21) || (ir_i == 8'h22);

  AST_STATE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $countones(tstate_o) == 1); // R2

  AST_STATE_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !halt_i |=> tstate_o == {$past(tstate_o[N-2:0]), $past(tstate_o[N-1])}); // R1

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    halt_i |=> tstate_o == $past(tstate_o)); // R11

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    halt_i |-> cword_o == 16'h0000); // R11

  AST_FETCH_WORD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tstate_o[0] && !halt_i) |-> cword_o == 16'h418F); // R4

  AST_UPPER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (|tstate_o[N-1:N/2]) |-> cword_o == 16'h0000); // R9

  AST_UNKNOWN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((|tstate_o[N-1:3]) && !known_op) |-> cword_o == 16'h0000); // R10

endmodule

bind useq_ctrl useq_chk #(.N(1 << SW), .OW(OW)) u_chk (
  .clk_i    (clk_i),
  .rst_n_i  (rst_n_i),
  .halt_i   (halt_i),
  .ir_i     (ir_i),
  .tstate_o (tstate_o),
  .cword_o  (cword_o)
);

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/100ps
module sim_useq_ctrl;

  typedef struct {
    logic [15:0] st;
    logic [15:0] cw;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        halt;
  logic [7:0]  ir;
  logic [15:0] tstate;
  logic [15:0] cword;

  int total;
  int bad;
  logic [3:0] cnt;
  item_t sbq[$];

  useq_ctrl u0 (
    .clk_i    (clk),
    .rst_n_i  (rst_n),
    .halt_i   (halt),
    .ir_i     (ir),
    .tstate_o (tstate),
    .cword_o  (cword)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] exp_word(logic [7:0] op, logic [3:0] s);
    if (s == 0) return 16'h418F;
    if (s == 1) return 16'h0028;
    if (s == 2) return 16'h0000;
    case (op)
      8'h11: case (s) 3: return 16'h418F; 4: return 16'h0001; default: return 16'h0; endcase
      8'h12: case (s) 3: return 16'h418F; 4: return 16'h0002; default: return 16'h0; endcase
      8'h21: case (s)
               3: return 16'h418A; 4: return 16'h418B; 5: return 16'h0025;
               6: return 16'h0036; 7: return 16'h001C; default: return 16'h0;
             endcase
      8'h22: case (s)
               3: return 16'h4189; 4: return 16'h418B; 5: return 16'h0024;
               6: return 16'h0036; 7: return 16'h001D; default: return 16'h0;
             endcase
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string exp_tag(logic [7:0] op, logic [3:0] s);
    if (s < 3) return "R4";
    if (s > 7) return "R9";
    case (op)
      8'h11: return (s > 4) ? "R9" : "R5";
      8'h12: return (s > 4) ? "R9" : "R6";
      8'h21: return "R7";
      8'h22: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one scoreboard item per cycle
  task automatic step(logic [7:0] op, logic h);
    item_t it;
    @(negedge clk);
    ir   = op;
    halt = h;
    it.st  = 16'h0001 << cnt;
    it.cw  = h ? 16'h0000 : exp_word(op, cnt);
    it.tag = h ? "R11" : exp_tag(op, cnt);
    sbq.push_back(it);
    if (!h) cnt = cnt + 4'd1;
  endtask

  task automatic run_op(logic [7:0] op);
    for (int k = 0; k < 16; k++) step(op, 1'b0);
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check("R1,R2 step", tstate, it.st);
      check(it.tag, cword, it.cw);
    end
  end

  initial begin
    total = 0;
    bad   = 0;
    cnt   = 4'd0;
    rst_n = 1'b0;
    halt  = 1'b0;
    ir    = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset step", tstate, 16'h0001);
    rst_n = 1'b1;
    cnt   = 4'd0;

    run_op(8'h11);   // R5
    run_op(8'h12);   // R6
    run_op(8'h21);   // R7
    run_op(8'h22);   // R8
    run_op(8'h00);   // R10
    run_op(8'hFF);   // R10
    run_op(8'h13);   // R10

    // R11: halt in the middle of a store, then resume
    for (int k = 0; k < 5; k++) step(8'h21, 1'b0);
    for (int k = 0; k < 3; k++) step(8'h21, 1'b1);
    for (int k = 0; k < 11; k++) step(8'h21, 1'b0);
    // halt while in the upper half
    for (int k = 0; k < 9; k++) step(8'h22, 1'b0);
    step(8'h22, 1'b1);
    step(8'h22, 1'b1);
    for (int k = 0; k < 7; k++) step(8'h22, 1'b0);

    // R3: reset in the middle of an instruction
    for (int k = 0; k < 6; k++) step(8'h11, 1'b0);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R3 mid-run reset step", tstate, 16'h0001);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    cnt   = 4'd0;
    run_op(8'h22);

    @(negedge clk);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule